// File: doc/BRIEF.md
# Adjacent-Face Die Roll Controller

This block keeps the face of a virtual six-sided die and moves it one roll at a time. Each roll tips the die onto one of the four faces next to the face now on top. It never stays where it is and never flips to the opposite face. A two-bit random input picks which of the four neighbours comes next. Rolls can only happen on every second clock after reset, because the random source it pairs with gives a fresh two-bit value only once per two cycles.

Next to the face code, the block drives a seven-bit pip vector in the usual die arrangement. The two codes that are not faces (0 and 7) produce their own error patterns, so a corrupted value can be seen on the display. Both outputs are registered and change on the same edge. A parameter sets the face loaded at reset. Its default is 1; the values 0 and 7 let an integrator, or a bench, start the block from an error state.

Top module: `dice_roll_ctrl`

## Requirements
- R1: While `rst_n` is low, `face` equals the parameter RESET_FACE (default 1), `pips` shows the pattern of that code, and the internal roll phase is cleared.
- R2: After reset is released, a roll may happen only on the 2nd, 4th, 6th… rising edge, and only if `roll_en` is high at that edge. On every other edge `face` and `pips` hold their values.
- R3: On a roll from a legal face f (1..6), the new face is taken from the list of faces in 1..6 other than f and 7−f, sorted in ascending order. `rand_bits` (0..3) indexes this list. For example, from 1 the codes 0,1,2,3 give 2,3,4,5, and from 4 they give 1,2,5,6.
- R4: A roll from a legal face never leaves the face unchanged.
- R5: A roll from a legal face never lands on the opposite face: old and new face never sum to 7.
- R6: `pips` bit positions are: 6 top-left, 5 mid-left, 4 bottom-left, 3 centre, 2 top-right, 1 mid-right, 0 bottom-right. Faces 1..6 give 0x08, 0x41, 0x49, 0x55, 0x5D and 0x77.
- R7: Code 0 gives `pips` 0x2A (middle row) and code 7 gives 0x7F (all pips).
- R8: A roll from code 0 or 7 always gives face 1, whatever the value of `rand_bits`.
- R9: `pips` always shows the pattern of the current `face` value. Both outputs change on the same edge.
- R10: Reset is asynchronous: `face` and `pips` go to their reset values as soon as `rst_n` falls, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| roll_en | input | 1 | Allows a roll on a roll-phase edge |
| rand_bits | input | 2 | Selects which neighbour comes next |
| face | output | 3 | Current face code, registered |
| pips | output | 7 | Pip drive pattern, registered |

## Verification
The bench builds three copies of the block. The first uses the default RESET_FACE of 1. The other two use RESET_FACE of 0 and of 7, which is the only way to reach the error pip patterns and the forced return to face 1 from outside the block. All three copies get the same random selections and enable pattern. A behavioural model computes each neighbour list from the adjacency rule, so every face/selection pair and the two-cycle roll timing are compared on every clock. A reset pulse that falls between clock edges checks the asynchronous path.

// File: rtl/dice_pkg.sv
`timescale 1ns/1ps
package dice_pkg;
  localparam int FACE_W   = 3;
  localparam int PIP_W    = 7;
  localparam int SEL_W    = 2;
  localparam int MAX_FACE = 6;
  localparam int OPP_SUM  = MAX_FACE + 1;
  localparam int N_NBR    = 1 << SEL_W;

  typedef logic [FACE_W-1:0] face_t;
  typedef logic [PIP_W-1:0]  pips_t;
  typedef logic [SEL_W-1:0]  sel_t;

  localparam face_t FACE_ONE = face_t'(1);

  // pip bit positions
  localparam int PIP_TL = 6;
  localparam int PIP_ML = 5;
  localparam int PIP_BL = 4;
  localparam int PIP_MC = 3;
  localparam int PIP_TR = 2;
  localparam int PIP_MR = 1;
  localparam int PIP_BR = 0;
endpackage

// File: rtl/dice_phase.sv
`timescale 1ns/1ps
module dice_phase (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_o <= 1'b0;
    else        phase_o <= ~phase_o;
  end

  assert_phase_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |=> phase_o);
  assert_phase_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o |=> !phase_o);
endmodule

// File: rtl/dice_nbr_sel.sv
`timescale 1ns/1ps
module dice_nbr_sel
  import dice_pkg::*;
(
  input  face_t face_i,
  input  sel_t  sel_i,
  output face_t next_o,
  output logic  legal_o
);
  always_comb begin
    int idx;
    int f;
    f       = int'(face_i);
    idx     = 0;
    legal_o = (f >= 1) && (f <= MAX_FACE);
    next_o  = FACE_ONE;
    for (int k = 1; k <= MAX_FACE; k++) begin
      if ((k != f) && (k != OPP_SUM - f)) begin
        if (idx == int'(sel_i)) next_o = face_t'(k);
        idx++;
      end
    end
    if (!legal_o) next_o = FACE_ONE;
  end
endmodule

// File: rtl/dice_pip_dec.sv
`timescale 1ns/1ps
module dice_pip_dec
  import dice_pkg::*;
(
  input  face_t face_i,
  output pips_t pips_o
);
  always_comb begin
    pips_o = '0;
    case (face_i)
      face_t'(1): pips_o[PIP_MC] = 1'b1;
      face_t'(2): begin
        pips_o[PIP_TL] = 1'b1; pips_o[PIP_BR] = 1'b1;
      end
      face_t'(3): begin
        pips_o[PIP_TL] = 1'b1; pips_o[PIP_MC] = 1'b1; pips_o[PIP_BR] = 1'b1;
      end
      face_t'(4): begin
        pips_o[PIP_TL] = 1'b1; pips_o[PIP_BL] = 1'b1;
        pips_o[PIP_TR] = 1'b1; pips_o[PIP_BR] = 1'b1;
      end
      face_t'(5): begin
        pips_o[PIP_TL] = 1'b1; pips_o[PIP_BL] = 1'b1; pips_o[PIP_MC] = 1'b1;
        pips_o[PIP_TR] = 1'b1; pips_o[PIP_BR] = 1'b1;
      end
      face_t'(6): begin
        pips_o[PIP_TL] = 1'b1; pips_o[PIP_ML] = 1'b1; pips_o[PIP_BL] = 1'b1;
        pips_o[PIP_TR] = 1'b1; pips_o[PIP_MR] = 1'b1; pips_o[PIP_BR] = 1'b1;
      end
      face_t'(0): begin
        pips_o[PIP_ML] = 1'b1; pips_o[PIP_MC] = 1'b1; pips_o[PIP_MR] = 1'b1;
      end
      default: pips_o = '1;
    endcase
  end
endmodule

// File: rtl/dice_roll_ctrl.sv
`timescale 1ns/1ps
module dice_roll_ctrl
  import dice_pkg::*;
#(
  parameter int RESET_FACE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       roll_en,
  input  logic [1:0] rand_bits,
  output logic [2:0] face,
  output logic [6:0] pips
);
  localparam face_t RST_FACE = face_t'(RESET_FACE);

  logic  phase;
  logic  roll;
  logic  legal;
  face_t nbr;
  pips_t nbr_pips;
  pips_t rst_pips;
  face_t face_q;
  pips_t pips_q;

  dice_phase u_phase (.clk(clk), .rst_n(rst_n), .phase_o(phase));

  dice_nbr_sel u_nbr (
    .face_i(face_q), .sel_i(sel_t'(rand_bits)), .next_o(nbr), .legal_o(legal)
  );

  dice_pip_dec u_dec_next (.face_i(nbr),      .pips_o(nbr_pips));
  dice_pip_dec u_dec_rst  (.face_i(RST_FACE), .pips_o(rst_pips));

  assign roll = phase & roll_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      face_q <= RST_FACE;
      pips_q <= rst_pips;
    end else if (roll) begin
      face_q <= nbr;
      pips_q <= nbr_pips;
    end
  end

  assign face = face_q;
  assign pips = pips_q;

  assert_hold_face_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(face_q));
  assert_hold_pips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(pips_q));
  assert_no_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && legal) |=> (face_q != $past(face_q)));
  assert_no_opposite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && legal) |=> (4'(face_q) + 4'($past(face_q)) != 4'(OPP_SUM)));
  assert_land_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (face_q >= 3'd1 && face_q <= 3'(MAX_FACE)));
  assert_error_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !legal) |=> (face_q == FACE_ONE));
endmodule

// File: tb/test_dice_roll_ctrl.sv
`timescale 1ns/1ps
module test_dice_roll_ctrl;
  localparam int NI = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] rnd = 2'd0;
  logic [2:0] face_w [NI];
  logic [6:0] pips_w [NI];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int rst_val [NI] = '{1, 0, 7};
  int mface   [NI];
  int mprev   [NI];
  bit mrolled;
  bit mphase;

  always #2 clk = ~clk;

  dice_roll_ctrl #(.RESET_FACE(1)) i_dice_roll_ctrl (
    .clk(clk), .rst_n(rst_n), .roll_en(en), .rand_bits(rnd),
    .face(face_w[0]), .pips(pips_w[0]));
  dice_roll_ctrl #(.RESET_FACE(0)) i_dice_roll_ctrl_zero (
    .clk(clk), .rst_n(rst_n), .roll_en(en), .rand_bits(rnd),
    .face(face_w[1]), .pips(pips_w[1]));
  dice_roll_ctrl #(.RESET_FACE(7)) i_dice_roll_ctrl_seven (
    .clk(clk), .rst_n(rst_n), .roll_en(en), .rand_bits(rnd),
    .face(face_w[2]), .pips(pips_w[2]));

  function automatic int exp_pips(int f);
    case (f)
      1: return 'h08;  2: return 'h41;  3: return 'h49;
      4: return 'h55;  5: return 'h5D;  6: return 'h77;
      0: return 'h2A;  default: return 'h7F;
    endcase
  endfunction

  function automatic int exp_next(int f, int sel);
    int q[$];
    if (f < 1 || f > 6) return 1;
    for (int k = 1; k <= 6; k++)
      if (k != f && k != 7 - f) q.push_back(k);
    return q[sel];
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mphase  <= 0;
      mrolled <= 0;
      for (int i = 0; i < NI; i++) mface[i] <= rst_val[i];
    end else begin
      mrolled <= mphase && en;
      if (mphase && en)
        for (int i = 0; i < NI; i++) begin
          mprev[i] <= mface[i];
          mface[i] <= exp_next(mface[i], int'(rnd));
        end
      mphase <= !mphase;
    end
  end

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NI; i++) begin
      check(mrolled ? "R3 face after roll" : "R2 face hold", int'(face_w[i]), mface[i]);
      check((mface[i] >= 1 && mface[i] <= 6) ? "R6 pips" : "R7 pips",
            int'(pips_w[i]), exp_pips(mface[i]));
      check("R9 pips follow face", int'(pips_w[i]), exp_pips(int'(face_w[i])));
    end
    if (mrolled) begin
      if (mprev[0] >= 1 && mprev[0] <= 6) begin
        check("R4 not same", int'(face_w[0] != 3'(mprev[0])), 1);
        check("R5 not opposite", int'(int'(face_w[0]) + mprev[0] != 7), 1);
      end
      check("R8 from code 0", int'(face_w[1]), exp_next(mprev[1], int'(rnd)));
    end
  endtask

  task automatic run(int cycles, bit rand_en);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      rnd = 2'($urandom_range(0, 3));
      en  = rand_en ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    @(negedge clk);
    // R1 / R7 reset values
    check("R1 face reset", int'(face_w[0]), 1);
    check("R1 pips reset", int'(pips_w[0]), 'h08);
    check("R1 face reset zero", int'(face_w[1]), 0);
    check("R7 pips code 0", int'(pips_w[1]), 'h2A);
    check("R1 face reset seven", int'(face_w[2]), 7);
    check("R7 pips code 7", int'(pips_w[2]), 'h7F);
    @(negedge clk);
    en = 1'b1;
    rnd = 2'd2;
    rst_n = 1'b1;
    run(300, 1'b0);
    run(300, 1'b1);
    // R10: asynchronous reset between edges
    @(negedge clk);
    compare_all();
    #1 rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < NI; i++) begin
      check("R10 async face", int'(face_w[i]), rst_val[i]);
      check("R10 async pips", int'(pips_w[i]), exp_pips(rst_val[i]));
    end
    @(negedge clk);
    rst_n = 1'b1;
    run(200, 1'b1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule